// File: doc/BRIEF.md
# Real-Mode Linear Address and Segment Limit Unit

This unit forms the linear address of a real-mode memory access. It takes a segment value and a 16-bit offset and adds the segment value shifted left by four to the offset. The carry out of that sum is kept, so the address is 21 bits wide. Before it issues the request, the unit checks that every byte of the access, from the first byte to the last, lies inside the 64 KB window of the segment. An access that would run past the top of the window, or a push that would run below offset zero, does not become a memory request. The unit raises a fault instead, and the fault vector depends on the access type and on the segment involved.

Three access types are supported: ordinary data, stack push and instruction fetch. A push decrements the offset it is given (the stack pointer) by the access size before the address is formed. A per-request compatibility input selects the older behaviour, in which offsets wrap modulo 65,536, the address is cut to 20 bits and no fault is ever raised. Results appear one clock after the request with the default configuration. Setting `OUT_REG` to 0 makes the result path combinational.

Top module: `rm_addr_unit`

## Requirements
- R1: Outside compatibility mode, an accepted access produces `lin_addr` = `seg_base`×16 + effective offset as a 21-bit value with no truncation. For example, `seg_base` FFFFh with offset FFFFh gives 10FFEFh.
- R2: For a data access (`acc_kind` 0, or the spare code 3), the last byte is offset + size − 1, computed in 17 bits. If it exceeds FFFFh, the access faults with vector 13 whenever `seg_sel` is not 2. The selector codes are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS, and codes 6 and 7 are treated like a non-stack segment.
- R3: The same data crossing faults with vector 12 when `seg_sel` is 2 (SS). A data access whose last byte is exactly FFFFh does not fault.
- R4: A push (`acc_kind` 1) subtracts the size from the offset and uses the result as the effective offset, which is reported on `eff_off`. If the offset is less than the size, the push faults with vector 12 whatever the selector. For example, a word push with an offset of 1 faults.
- R5: An instruction fetch (`acc_kind` 2) whose last byte exceeds FFFFh faults with vector 13 whatever the selector.
- R6: With `compat` high, no access faults. The effective offset wraps modulo 65,536 and `lin_addr[20]` is 0, so FFFFh:FFFFh gives 0FFEFh.
- R7: `size_code` 0, 1, 2 and 3 mean 1, 2, 4 and 4 bytes. A 4-byte data access at FFFCh is accepted, and one at FFFDh faults.
- R8: Each request (`req_valid` high) produces exactly one of `mem_req` or `fault` one cycle later. A cycle without a request produces neither. `lin_addr` and `eff_off` are 0 whenever `mem_req` is low, and `fault_vec` is 0 whenever `fault` is low.
- R9: While reset is held, and until the first request after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| seg_sel | input | 3 | Segment code: 0=ES 1=CS 2=SS 3=DS 4=FS 5=GS |
| seg_base | input | 16 | Segment register value |
| offset | input | 16 | Offset, or stack pointer for a push |
| size_code | input | 2 | 0:1 byte, 1:2 bytes, 2 or 3:4 bytes |
| acc_kind | input | 2 | 0 data, 1 push, 2 fetch, 3 data |
| compat | input | 1 | Wrap-around compatibility behaviour |
| mem_req | output | 1 | Memory request strobe |
| lin_addr | output | 21 | Linear address of the first byte |
| eff_off | output | 16 | Effective offset used for the access |
| fault | output | 1 | Fault strobe |
| fault_vec | output | 8 | Fault vector, 12 or 13 |

## Verification
On every cycle, the bound properties check the following rules:
- a request produces exactly one outcome, and an idle cycle produces neither;
- the address and offset outputs stay at zero without a request, and the vector stays at zero without a fault;
- a fault vector is always 12 or 13;
- compatibility mode never faults and always clears address bit 20;
- a word push from offset 1, or a stack-segment word read at FFFFh, always raises vector 12.

The exact address arithmetic and the push pre-decrement are shown only by the bench's directed scenarios. These include the FFFFh:FFFFh carry into bit 20, the 4-byte boundary at FFFCh and FFFDh, the selector sweep across all eight codes, and back-to-back requests.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;

   localparam logic [2:0] SEG_ES = 3'd0;
   localparam logic [2:0] SEG_CS = 3'd1;
   localparam logic [2:0] SEG_SS = 3'd2;
   localparam logic [2:0] SEG_DS = 3'd3;
   localparam logic [2:0] SEG_FS = 3'd4;
   localparam logic [2:0] SEG_GS = 3'd5;

   typedef enum logic [1:0] {
      ACC_DATA  = 2'd0,
      ACC_PUSH  = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_SPARE = 2'd3
   } acc_kind_e;

   localparam int VEC_STACK = 12;
   localparam int VEC_GPROT = 13;

   // byte count of an access size code, at a caller-chosen width
   function automatic int size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

endpackage

// File: rtl/rm_span_check.sv
module rm_span_check
   import rm_addr_pkg::*;
#(
   parameter int OFF_W = 16
) (
   input  logic [OFF_W-1:0] offset,
   input  logic [1:0]       size_code,
   input  logic [1:0]       acc_kind,
   input  logic             compat,
   output logic [OFF_W-1:0] eff_off,
   output logic             span_fault
);
   localparam int XW = OFF_W + 1;

   logic [XW-1:0] nbytes;
   logic [XW-1:0] ext_off;
   logic [XW-1:0] dec_off;
   logic [XW-1:0] last_byte;
   logic          is_push;

   always_comb begin
      nbytes    = XW'(size_bytes(size_code));
      ext_off   = {1'b0, offset};
      dec_off   = ext_off - nbytes;
      last_byte = ext_off + nbytes - XW'(1);
      is_push   = (acc_kind == ACC_PUSH);
   end

   always_comb begin
      if (is_push) begin
         eff_off    = dec_off[OFF_W-1:0];
         span_fault = !compat && dec_off[OFF_W];
      end else begin
         eff_off    = offset;
         span_fault = !compat && last_byte[OFF_W];
      end
   end

endmodule

// File: rtl/rm_fault_sel.sv
module rm_fault_sel
   import rm_addr_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic [2:0]       seg_sel,
   input  logic [1:0]       acc_kind,
   output logic [VEC_W-1:0] vec
);
   always_comb begin
      case (acc_kind)
         ACC_PUSH:  vec = VEC_W'(VEC_STACK);
         ACC_FETCH: vec = VEC_W'(VEC_GPROT);
         default:   vec = (seg_sel == SEG_SS) ? VEC_W'(VEC_STACK)
                                              : VEC_W'(VEC_GPROT);
      endcase
   end

endmodule

// File: rtl/rm_lin_form.sv
module rm_lin_form #(
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int LIN_W     = OFF_W + SEG_SHIFT + 1
) (
   input  logic [OFF_W-1:0] seg_base,
   input  logic [OFF_W-1:0] eff_off,
   input  logic             compat,
   output logic [LIN_W-1:0] lin
);
   logic [LIN_W-1:0] sum;

   always_comb begin
      sum = LIN_W'({seg_base, {SEG_SHIFT{1'b0}}}) + LIN_W'(eff_off);
      lin = compat ? {1'b0, sum[LIN_W-2:0]} : sum;
   end

endmodule

// File: rtl/rm_addr_unit.sv
module rm_addr_unit
   import rm_addr_pkg::*;
#(
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int VEC_W     = 8,
   parameter bit OUT_REG   = 1'b1,
   localparam int LIN_W    = OFF_W + SEG_SHIFT + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       seg_sel,
   input  logic [OFF_W-1:0] seg_base,
   input  logic [OFF_W-1:0] offset,
   input  logic [1:0]       size_code,
   input  logic [1:0]       acc_kind,
   input  logic             compat,
   output logic             mem_req,
   output logic [LIN_W-1:0] lin_addr,
   output logic [OFF_W-1:0] eff_off,
   output logic             fault,
   output logic [VEC_W-1:0] fault_vec
);
   if (OFF_W < 8) begin : g_bad_off
      $error("rm_addr_unit: OFF_W must be at least 8");
   end
   if (SEG_SHIFT < 1) begin : g_bad_shift
      $error("rm_addr_unit: SEG_SHIFT must be at least 1");
   end
   if (VEC_W < 4) begin : g_bad_vec
      $error("rm_addr_unit: VEC_W must hold vector 13");
   end

   logic [OFF_W-1:0] c_off;
   logic             c_span_fault;
   logic [VEC_W-1:0] c_vec;
   logic [LIN_W-1:0] c_lin;

   rm_span_check #(.OFF_W(OFF_W)) u_span (
      .offset     (offset),
      .size_code  (size_code),
      .acc_kind   (acc_kind),
      .compat     (compat),
      .eff_off    (c_off),
      .span_fault (c_span_fault)
   );

   rm_fault_sel #(.VEC_W(VEC_W)) u_vsel (
      .seg_sel  (seg_sel),
      .acc_kind (acc_kind),
      .vec      (c_vec)
   );

   rm_lin_form #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT), .LIN_W(LIN_W)) u_lin (
      .seg_base (seg_base),
      .eff_off  (c_off),
      .compat   (compat),
      .lin      (c_lin)
   );

   logic             n_req;
   logic             n_fault;
   logic [VEC_W-1:0] n_vec;
   logic [LIN_W-1:0] n_lin;
   logic [OFF_W-1:0] n_off;

   always_comb begin
      n_req   = req_valid && !c_span_fault;
      n_fault = req_valid && c_span_fault;
      n_vec   = n_fault ? c_vec : '0;
      n_lin   = n_req ? c_lin : '0;
      n_off   = n_req ? c_off : '0;
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mem_req   <= 1'b0;
            fault     <= 1'b0;
            fault_vec <= '0;
            lin_addr  <= '0;
            eff_off   <= '0;
         end else begin
            mem_req   <= n_req;
            fault     <= n_fault;
            fault_vec <= n_vec;
            lin_addr  <= n_lin;
            eff_off   <= n_off;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         mem_req   = n_req;
         fault     = n_fault;
         fault_vec = n_vec;
         lin_addr  = n_lin;
         eff_off   = n_off;
      end
   end

endmodule

// File: rtl/rm_addr_unit_chk.sv
module rm_addr_unit_chk
   import rm_addr_pkg::*;
#(
   parameter int OFF_W   = 16,
   parameter int VEC_W   = 8,
   parameter int LIN_W   = 21,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [2:0]       seg_sel,
   input logic [OFF_W-1:0] offset,
   input logic [1:0]       size_code,
   input logic [1:0]       acc_kind,
   input logic             compat,
   input logic             mem_req,
   input logic [LIN_W-1:0] lin_addr,
   input logic [OFF_W-1:0] eff_off,
   input logic             fault,
   input logic [VEC_W-1:0] fault_vec
);
   if (OUT_REG) begin : g_props
      p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> (mem_req != fault));

      p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> (!mem_req && !fault));

      p_zero_when_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !mem_req |-> (lin_addr == '0 && eff_off == '0));

      p_vec_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !fault |-> (fault_vec == '0));

      p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
         fault |-> (fault_vec == VEC_W'(VEC_STACK) || fault_vec == VEC_W'(VEC_GPROT)));

      p_compat_nofault_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && compat) |=> (mem_req && !fault));

      p_compat_a20_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && compat) |=> !lin_addr[LIN_W-1]);

      p_push_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !compat && acc_kind == ACC_PUSH && size_code == 2'd1
          && offset < OFF_W'(2)) |=> (fault && fault_vec == VEC_W'(VEC_STACK)));

      p_ss_cross_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && !compat && acc_kind == ACC_DATA && seg_sel == SEG_SS
          && size_code != 2'd0 && offset == '1)
         |=> (fault && fault_vec == VEC_W'(VEC_STACK)));
   end

endmodule

bind rm_addr_unit rm_addr_unit_chk #(
   .OFF_W   (OFF_W),
   .VEC_W   (VEC_W),
   .LIN_W   (LIN_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .seg_sel   (seg_sel),
   .offset    (offset),
   .size_code (size_code),
   .acc_kind  (acc_kind),
   .compat    (compat),
   .mem_req   (mem_req),
   .lin_addr  (lin_addr),
   .eff_off   (eff_off),
   .fault     (fault),
   .fault_vec (fault_vec)
);

// File: tb/rm_addr_unit_bench.sv
`timescale 1ns/1ps
module rm_addr_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  seg_sel = '0;
   logic [15:0] seg_base = '0;
   logic [15:0] offset = '0;
   logic [1:0]  size_code = '0;
   logic [1:0]  acc_kind = '0;
   logic        compat = 1'b0;
   logic        mem_req;
   logic [20:0] lin_addr;
   logic [15:0] eff_off;
   logic        fault;
   logic [7:0]  fault_vec;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rm_addr_unit u_rm_addr_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .seg_sel   (seg_sel),
      .seg_base  (seg_base),
      .offset    (offset),
      .size_code (size_code),
      .acc_kind  (acc_kind),
      .compat    (compat),
      .mem_req   (mem_req),
      .lin_addr  (lin_addr),
      .eff_off   (eff_off),
      .fault     (fault),
      .fault_vec (fault_vec)
   );

   typedef struct {
      bit          req;
      bit          flt;
      logic [7:0]  vec;
      logic [20:0] lin;
      logic [15:0] off;
      string       tag;
   } exp_t;

   exp_t sb[$];

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected result built from the requirement text
   function automatic exp_t model(input logic [2:0] s, input logic [15:0] b,
                                  input logic [15:0] o, input logic [1:0] z,
                                  input logic [1:0] k, input bit c, input string tag);
      exp_t e;
      int n;
      int eo;
      int last;
      bit bad;
      logic [7:0] v;
      int lin;
      n = (z == 2'd0) ? 1 : (z == 2'd1) ? 2 : 4;
      if (k == 2'd1) begin
         bad = (int'(o) < n);
         eo  = (int'(o) - n) & 32'hFFFF;
         v   = 8'd12;
      end else begin
         last = int'(o) + n - 1;
         bad  = (last > 32'hFFFF);
         eo   = int'(o);
         v    = (k == 2'd2) ? 8'd13 : (s == 3'd2) ? 8'd12 : 8'd13;
      end
      if (c) bad = 1'b0;
      lin = int'(b) * 16 + eo;
      if (c) lin = lin % 32'h100000;
      e.tag = tag;
      e.req = !bad;
      e.flt = bad;
      e.vec = bad ? v : 8'd0;
      e.lin = bad ? 21'd0 : 21'(lin);
      e.off = bad ? 16'd0 : 16'(eo);
      return e;
   endfunction

   task automatic send(input logic [2:0] s, input logic [15:0] b, input logic [15:0] o,
                       input logic [1:0] z, input logic [1:0] k, input bit c,
                       input string tag);
      @(negedge clk);
      seg_sel = s; seg_base = b; offset = o; size_code = z; acc_kind = k; compat = c;
      req_valid = 1'b1;
      sb.push_back(model(s, b, o, z, k, c, tag));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
      end
   endtask

   // monitor: one result per request, checked a little after the edge
   initial begin
      forever begin
         bit v;
         @(posedge clk);
         v = req_valid && rst_n;
         #1;
         if (v) begin
            if (sb.size() == 0) begin
               check("R8 unexpected result", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check({e.tag, " mem_req"}, 64'(mem_req), 64'(e.req));
               check({e.tag, " fault"}, 64'(fault), 64'(e.flt));
               check({e.tag, " fault_vec"}, 64'(fault_vec), 64'(e.vec));
               check({e.tag, " lin_addr"}, 64'(lin_addr), 64'(e.lin));
               check({e.tag, " eff_off"}, 64'(eff_off), 64'(e.off));
            end
         end else if (rst_n) begin
            check("R8 idle quiet", 64'({mem_req, fault}), 64'd0);
         end
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: outputs zero under reset
      check("R9 reset outputs", 64'({mem_req, fault, fault_vec, lin_addr, eff_off}), 64'd0);
      rst_n = 1'b1;
      idle(2);
      check("R9 after reset", 64'({mem_req, fault, fault_vec, lin_addr, eff_off}), 64'd0);

      // R1: address forming and carry into bit 20
      send(3'd3, 16'h1234, 16'h0010, 2'd0, 2'd0, 1'b0, "R1 ds basic");
      send(3'd3, 16'hFFFF, 16'hFFFF, 2'd0, 2'd0, 1'b0, "R1 a20 kept");
      send(3'd0, 16'h0000, 16'h0000, 2'd1, 2'd0, 1'b0, "R1 zero");
      idle(1);

      // R2 and R3: data crossing across the selector codes
      for (int s = 0; s < 8; s++) begin
         send(3'(s), 16'h2000, 16'hFFFF, 2'd1, 2'd0, 1'b0, $sformatf("R2 R3 cross sel%0d", s));
      end
      send(3'd2, 16'h2000, 16'hFFFE, 2'd1, 2'd0, 1'b0, "R3 ss last byte at top");
      send(3'd4, 16'h0100, 16'hFFFF, 2'd1, 2'd3, 1'b0, "R2 spare kind as data");
      idle(2);

      // R4: push pre-decrement and underflow
      send(3'd2, 16'h3000, 16'h0001, 2'd1, 2'd1, 1'b0, "R4 word push sp1");
      send(3'd2, 16'h3000, 16'h0002, 2'd1, 2'd1, 1'b0, "R4 word push sp2");
      send(3'd2, 16'h3000, 16'h0100, 2'd2, 2'd1, 1'b0, "R4 dword push");
      send(3'd3, 16'h3000, 16'h0003, 2'd2, 2'd1, 1'b0, "R4 dword push sp3");
      send(3'd2, 16'h3000, 16'h0000, 2'd0, 2'd1, 1'b0, "R4 byte push sp0");

      // R5: fetch crossing
      send(3'd2, 16'h0F00, 16'hFFFF, 2'd1, 2'd2, 1'b0, "R5 fetch cross");
      send(3'd1, 16'h0F00, 16'hFFFF, 2'd0, 2'd2, 1'b0, "R5 fetch last byte");
      idle(1);

      // R6: compatibility wrap
      send(3'd3, 16'hFFFF, 16'hFFFF, 2'd0, 2'd0, 1'b1, "R6 wrap 1MB");
      send(3'd2, 16'h1000, 16'hFFFF, 2'd1, 2'd0, 1'b1, "R6 no cross fault");
      send(3'd2, 16'h1000, 16'h0001, 2'd1, 2'd1, 1'b1, "R6 push wrap");
      send(3'd1, 16'h1000, 16'hFFFE, 2'd2, 2'd2, 1'b1, "R6 fetch wrap");

      // R7: size codes at the top boundary
      send(3'd3, 16'h0040, 16'hFFFC, 2'd2, 2'd0, 1'b0, "R7 dword at FFFC");
      send(3'd3, 16'h0040, 16'hFFFD, 2'd2, 2'd0, 1'b0, "R7 dword at FFFD");
      send(3'd3, 16'h0040, 16'hFFFC, 2'd3, 2'd0, 1'b0, "R7 code3 at FFFC");
      send(3'd3, 16'h0040, 16'hFFFD, 2'd3, 2'd0, 1'b0, "R7 code3 at FFFD");
      send(3'd3, 16'h0040, 16'hFFFF, 2'd0, 2'd0, 1'b0, "R7 byte at FFFF");
      idle(4);

      check("R8 scoreboard drained", 64'(sb.size()), 64'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule